// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small integer processor core built as five overlapping stages: fetch, decode with register read, execute, memory access and register write-back. A clocked register between each pair of neighbouring stages carries everything the later stage needs. The register file, written in the last stage, takes the place of a register after it. The core supports five operations: register add, register subtract, word load, word store and branch-if-equal.

The core reads instructions through a combinational instruction port. It reads and writes data through a combinational data port, with writes taking effect on the clock edge. There are no forwarding paths. A decode-stage instruction whose source register is still being produced in execute or memory waits in decode, and a bubble goes down the pipe behind the producer. A taken branch is settled in the memory stage. It discards the three younger instructions and redirects fetch.

Each instruction that completes is reported on a retire strobe together with its own address. This makes the order and timing of completion visible at the ports.

Top module: `pipe5_core`

## Requirements
- R1: While reset is held, and in the first cycle after it, the fetch address is 0, no store is issued and the retire strobe is low.
- R2: Instructions retire in program order, each once, with its own address on retirePc. After reset is released, the first instruction retires at the 4th rising edge. Without hazards, one instruction retires every cycle, and the fetch address advances by 4 each cycle unless stalled or redirected.
- R3: A word with bits [31:26]=0, shamt bits [10:6]=0 and function bits [5:0]=0x20 writes rs+rt into rd. With function 0x22 it writes rs-rt into rd. The fields are rs [25:21], rt [20:16] and rd [15:11].
- R4: Opcode 0x23 loads the data word at address rs + sign-extended bits [15:0] into rt. Opcode 0x2B writes rt to that same address. The data address is driven in the memory stage.
- R5: Opcode 0x04 compares rs and rt. When they are equal, the next fetch is at its address + 4 + (sign-extended immediate shifted left by 2). Otherwise execution falls through with no lost cycle.
- R6: An instruction that reads a register written by an older instruction still in execute or memory is held in decode, with bubbles, until the producer reaches write-back. Its retirement then comes at least 3 cycles after the producer's retirement. A producer in write-back causes no stall.
- R7: A taken branch discards the three instructions behind it. None of them stores or retires, and the next retirement comes 4 cycles after the branch retires.
- R8: Register 0 reads as zero, writes to it are dropped, and it never causes a stall.
- R9: Any other word, including a register-form word with nonzero shamt or another function code, retires as a no-op. It writes nothing, stores nothing and reads no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | XLEN | Fetch address |
| imemData | input | 32 | Instruction word at imemAddr, same cycle |
| dmemAddr | output | XLEN | Data address for load or store |
| dmemWrEn | output | 1 | Store strobe, written at the next rising edge |
| dmemWrData | output | XLEN | Store data |
| dmemRdData | input | XLEN | Data word at dmemAddr, same cycle |
| retireValid | output | 1 | An instruction completes this cycle |
| retirePc | output | XLEN | Address of the completing instruction |

## Verification
A directed program places a dependent pair at distance one, a taken and a not-taken branch, a store shadowed by a taken branch, a write to register 0 and an unknown word. Each checks a different rule: stall length, branch penalty, flush of younger work, the zero register and no-op handling. Seeded random programs over a few registers mix all five operations with forward branches, negative offsets and dependence chains of varied distance, so that overlapping stalls and flushes meet. Every retirement's address and cycle, and every store's address and data, are compared with an in-order reference. Its timing rules distinguish a missing interlock (too early) from an over-eager one (too late).

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int INSN_W = 32;
  localparam int RIDX   = 5;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] FUN_ADD   = 6'h20;
  localparam logic [5:0] FUN_SUB   = 6'h22;

  typedef enum logic [2:0] {
    KIND_NOP, KIND_ADD, KIND_SUB, KIND_LOAD, KIND_STORE, KIND_BEQ
  } instKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stall;
    logic flush;
  } pipeCtl_t;

  // what control needs to see of the datapath
  typedef struct packed {
    logic [1:0]           srcUse;
    logic [1:0][RIDX-1:0] srcReg;
    logic                 exWr;
    logic [RIDX-1:0]      exDst;
    logic                 memWr;
    logic [RIDX-1:0]      memDst;
    logic                 memTaken;
  } hazView_t;

  function automatic instKind_t decodeKind(input logic [INSN_W-1:0] w);
    instKind_t k;
    k = KIND_NOP;
    case (w[31:26])
      OPC_REG: begin
        if (w[10:6] == 5'd0 && w[5:0] == FUN_ADD) k = KIND_ADD;
        else if (w[10:6] == 5'd0 && w[5:0] == FUN_SUB) k = KIND_SUB;
      end
      OPC_LOAD:  k = KIND_LOAD;
      OPC_STORE: k = KIND_STORE;
      OPC_BEQ:   k = KIND_BEQ;
      default:   k = KIND_NOP;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/pipe5_regs.sv
module pipe5_regs
  import pipe5_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int PORTS = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PORTS-1:0][RIDX-1:0]  rdAddr,
  output logic [PORTS-1:0][XLEN-1:0]  rdData,
  input  logic                        wrEn,
  input  logic [RIDX-1:0]             wrAddr,
  input  logic [XLEN-1:0]             wrData
);
  localparam int NREG = 2 ** RIDX;

  logic [XLEN-1:0] regArr [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regArr[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regArr[wrAddr] <= wrData;
    end
  end

  // write in the first half: a same-cycle write is seen by the read
  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    always_comb begin
      if (rdAddr[p] == '0)                        rdData[p] = '0;
      else if (wrEn && wrAddr == rdAddr[p])       rdData[p] = wrData;
      else                                        rdData[p] = regArr[rdAddr[p]];
    end
  end
endmodule

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
  import pipe5_pkg::*;
(
  input  hazView_t hv,
  output pipeCtl_t ctl
);
  logic [1:0] srcHit;

  for (genvar s = 0; s < 2; s++) begin : g_src
    assign srcHit[s] = hv.srcUse[s] && (hv.srcReg[s] != '0) &&
                       ((hv.exWr  && hv.exDst  == hv.srcReg[s]) ||
                        (hv.memWr && hv.memDst == hv.srcReg[s]));
  end

  always_comb begin
    ctl.flush = hv.memTaken;
    ctl.stall = !hv.memTaken && (|srcHit);
  end
endmodule

// File: rtl/pipe5_dpath.sv
module pipe5_dpath
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  pipeCtl_t          ctl,
  output hazView_t          hv,
  output logic [XLEN-1:0]   imemAddr,
  input  logic [INSN_W-1:0] imemData,
  output logic [XLEN-1:0]   dmemAddr,
  output logic              dmemWrEn,
  output logic [XLEN-1:0]   dmemWrData,
  input  logic [XLEN-1:0]   dmemRdData,
  output logic              retireValid,
  output logic [XLEN-1:0]   retirePc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  localparam int IMM_W = 16;

  // fetch
  logic [XLEN-1:0] pcQ;

  // IF/ID
  logic              ifidValid;
  logic [INSN_W-1:0] ifidInstr;
  logic [XLEN-1:0]   ifidPc, ifidPcInc;

  // decode
  instKind_t         idKind;
  logic [RIDX-1:0]   idRs, idRt, idRd, idDst;
  logic              idWr;
  logic [XLEN-1:0]   idImm;
  logic [1:0][RIDX-1:0] rfAddr;
  logic [1:0][XLEN-1:0] rfData;

  // ID/EX
  logic              idexValid, idexWr;
  instKind_t         idexKind;
  logic [XLEN-1:0]   idexPc, idexPcInc, idexA, idexB, idexImm;
  logic [RIDX-1:0]   idexDst;

  // execute
  logic [XLEN-1:0]   exRes, exTarget;
  logic              exEq;

  // EX/MEM
  logic              exmemValid, exmemWr, exmemTaken;
  instKind_t         exmemKind;
  logic [XLEN-1:0]   exmemPc, exmemRes, exmemB, exmemTarget;
  logic [RIDX-1:0]   exmemDst;

  // MEM/WB
  logic              memwbValid, memwbWr;
  logic [XLEN-1:0]   memwbPc, memwbData;
  logic [RIDX-1:0]   memwbDst;

  // ---------------- fetch ----------------
  always_ff @(posedge clk) begin
    if (rst)               pcQ <= '0;
    else if (ctl.flush)    pcQ <= exmemTarget;
    else if (!ctl.stall)   pcQ <= pcQ + STEP;
  end
  assign imemAddr = pcQ;

  always_ff @(posedge clk) begin
    if (rst || ctl.flush) begin
      ifidValid <= 1'b0;
    end else if (!ctl.stall) begin
      ifidValid <= 1'b1;
      ifidInstr <= imemData;
      ifidPc    <= pcQ;
      ifidPcInc <= pcQ + STEP;
    end
  end

  // ---------------- decode ----------------
  always_comb begin
    idKind = ifidValid ? decodeKind(ifidInstr) : KIND_NOP;
    idRs   = ifidInstr[25:21];
    idRt   = ifidInstr[20:16];
    idRd   = ifidInstr[15:11];
    idImm  = {{(XLEN-IMM_W){ifidInstr[IMM_W-1]}}, ifidInstr[IMM_W-1:0]};
    idWr   = (idKind == KIND_ADD) || (idKind == KIND_SUB) || (idKind == KIND_LOAD);
    idDst  = (idKind == KIND_LOAD) ? idRt : idRd;
  end

  assign rfAddr[0] = idRs;
  assign rfAddr[1] = idRt;

  pipe5_regs #(.XLEN(XLEN), .PORTS(2)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .rdAddr (rfAddr),
    .rdData (rfData),
    .wrEn   (memwbWr),
    .wrAddr (memwbDst),
    .wrData (memwbData)
  );

  always_ff @(posedge clk) begin
    if (rst || ctl.flush || ctl.stall) begin
      idexValid <= 1'b0;
      idexWr    <= 1'b0;
      idexKind  <= KIND_NOP;
    end else begin
      idexValid <= ifidValid;
      idexWr    <= idWr;
      idexKind  <= idKind;
      idexPc    <= ifidPc;
      idexPcInc <= ifidPcInc;
      idexA     <= rfData[0];
      idexB     <= rfData[1];
      idexImm   <= idImm;
      idexDst   <= idDst;
    end
  end

  // ---------------- execute ----------------
  always_comb begin
    exEq     = (idexA == idexB);
    exTarget = idexPcInc + {idexImm[XLEN-3:0], 2'b00};
    case (idexKind)
      KIND_ADD: exRes = idexA + idexB;
      KIND_SUB: exRes = idexA - idexB;
      default:  exRes = idexA + idexImm;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.flush) begin
      exmemValid <= 1'b0;
      exmemWr    <= 1'b0;
      exmemTaken <= 1'b0;
      exmemKind  <= KIND_NOP;
    end else begin
      exmemValid  <= idexValid;
      exmemWr     <= idexWr;
      exmemTaken  <= idexValid && (idexKind == KIND_BEQ) && exEq;
      exmemKind   <= idexKind;
      exmemPc     <= idexPc;
      exmemRes    <= exRes;
      exmemB      <= idexB;
      exmemTarget <= exTarget;
      exmemDst    <= idexDst;
    end
  end

  // ---------------- memory ----------------
  assign dmemAddr   = exmemRes;
  assign dmemWrData = exmemB;
  assign dmemWrEn   = exmemValid && (exmemKind == KIND_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      memwbValid <= 1'b0;
      memwbWr    <= 1'b0;
    end else begin
      memwbValid <= exmemValid;
      memwbWr    <= exmemValid && exmemWr;
      memwbPc    <= exmemPc;
      memwbDst   <= exmemDst;
      memwbData  <= (exmemKind == KIND_LOAD) ? dmemRdData : exmemRes;
    end
  end

  // ---------------- write-back / retire ----------------
  assign retireValid = memwbValid;
  assign retirePc    = memwbPc;

  // ---------------- hazard view ----------------
  always_comb begin
    hv.srcUse[0] = (idKind != KIND_NOP);
    hv.srcUse[1] = (idKind == KIND_ADD) || (idKind == KIND_SUB) ||
                   (idKind == KIND_STORE) || (idKind == KIND_BEQ);
    hv.srcReg    = rfAddr;
    hv.exWr      = idexValid && idexWr;
    hv.exDst     = idexDst;
    hv.memWr     = exmemValid && exmemWr;
    hv.memDst    = exmemDst;
    hv.memTaken  = exmemValid && exmemTaken;
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   imemAddr,
  input  logic [INSN_W-1:0] imemData,
  output logic [XLEN-1:0]   dmemAddr,
  output logic              dmemWrEn,
  output logic [XLEN-1:0]   dmemWrData,
  input  logic [XLEN-1:0]   dmemRdData,
  output logic              retireValid,
  output logic [XLEN-1:0]   retirePc
);
  pipeCtl_t ctlBus;
  hazView_t hazBus;

  pipe5_ctrl u_ctrl (
    .hv  (hazBus),
    .ctl (ctlBus)
  );

  pipe5_dpath #(.XLEN(XLEN)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctlBus),
    .hv          (hazBus),
    .imemAddr    (imemAddr),
    .imemData    (imemData),
    .dmemAddr    (dmemAddr),
    .dmemWrEn    (dmemWrEn),
    .dmemWrData  (dmemWrData),
    .dmemRdData  (dmemRdData),
    .retireValid (retireValid),
    .retirePc    (retirePc)
  );
endmodule

// File: rtl/pipe5_chk.sv
module pipe5_chk
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imemAddr,
  input logic            dmemWrEn,
  input logic            retireValid,
  input pipeCtl_t        ctl
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!retireValid && !dmemWrEn && imemAddr == '0)); // R1

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctl.flush) && !$past(ctl.stall))
      |-> imemAddr == $past(imemAddr) + XLEN'(4)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl.stall)) |-> imemAddr == $past(imemAddr)); // R6

  AST_FLUSH_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    ctl.flush |=> !dmemWrEn); // R7

  AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.flush, 2) |-> !retireValid); // R7
endmodule

bind pipe5_core pipe5_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .imemAddr    (imemAddr),
  .dmemWrEn    (dmemWrEn),
  .retireValid (retireValid),
  .ctl         (ctlBus)
);

// File: tb/sim_pipe5_core.sv
`timescale 1ns/1ps
module sim_pipe5_core;
  localparam int XLEN = 32;
  localparam int MAXR = 256;
  localparam int PLEN = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [XLEN-1:0] imemAddr, dmemAddr, dmemWrData, dmemRdData, retirePc;
  logic [31:0]     imemData;
  logic            dmemWrEn, retireValid;

  pipe5_core #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst),
    .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrEn(dmemWrEn), .dmemWrData(dmemWrData),
    .dmemRdData(dmemRdData),
    .retireValid(retireValid), .retirePc(retirePc)
  );

  always #4 clk = ~clk;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] dmemInit [64];

  assign imemData   = imem[imemAddr[7:2]];
  assign dmemRdData = dmem[dmemAddr[7:2]];
  always @(posedge clk) if (dmemWrEn) dmem[dmemAddr[7:2]] <= dmemWrData;

  int total = 0;
  int bad   = 0;

  // expected trace
  int          expN, expNs;
  logic [31:0] expPc [MAXR];
  int          expCyc [MAXR];
  string       expPTag [MAXR];
  string       expCTag [MAXR];
  logic [31:0] expSa [MAXR];
  logic [31:0] expSd [MAXR];
  string       expSTag [MAXR];

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(int fn, int rd, int rs, int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  function automatic logic [31:0] encI(int op, int rs, int rt, logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  // in-order reference with timing rules from R2, R6, R7
  task automatic runIss();
    logic [31:0] r [32];
    int          lastRet [32];
    logic [31:0] mem [64];
    int          pcIdx, prevRet, loops;
    bit          prevTaken;
    pcIdx = 0; prevRet = 0; loops = 0; prevTaken = 0;
    for (int i = 0; i < 32; i++) begin r[i] = '0; lastRet[i] = -100; end
    for (int i = 0; i < 64; i++) mem[i] = dmemInit[i];
    expN = 0; expNs = 0;
    while (expN < MAXR && loops < 3) begin
      logic [31:0] w, a, b, sx, pcB, val, addr, tgt;
      int kind, rs, rt, rd, dst, t, nextIdx;
      bit useRs, useRt, taken;
      string cTag;
      w  = imem[pcIdx[5:0]];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      sx = {{16{w[15]}}, w[15:0]};
      kind = 0;
      if (w[31:26] == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h20) kind = 1;
      else if (w[31:26] == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h22) kind = 2;
      else if (w[31:26] == 6'h23) kind = 3;
      else if (w[31:26] == 6'h2B) kind = 4;
      else if (w[31:26] == 6'h04) kind = 5;
      useRs = (kind != 0);
      useRt = (kind == 1) || (kind == 2) || (kind == 4) || (kind == 5);
      t = (expN == 0) ? 4 : prevRet + 1;
      cTag = "R2";
      if (prevTaken && prevRet + 4 > t) begin t = prevRet + 4; cTag = "R7"; end
      if (useRs && rs != 0 && lastRet[rs] + 3 > t) begin t = lastRet[rs] + 3; cTag = "R6"; end
      if (useRt && rt != 0 && lastRet[rt] + 3 > t) begin t = lastRet[rt] + 3; cTag = "R6"; end
      a = r[rs]; b = r[rt];
      pcB = 32'(pcIdx * 4);
      nextIdx = pcIdx + 1; taken = 0; dst = 0; val = '0;
      addr = a + sx;
      case (kind)
        1: begin dst = rd; val = a + b; end
        2: begin dst = rd; val = a - b; end
        3: begin dst = rt; val = mem[addr[7:2]]; end
        4: begin
          mem[addr[7:2]] = b;
          expSa[expNs] = addr; expSd[expNs] = b;
          expSTag[expNs] = (rt == 0) ? "R8" : "R3";
          expNs++;
        end
        5: if (a == b) begin
          taken = 1;
          tgt = pcB + 32'd4 + {sx[29:0], 2'b00};
          nextIdx = int'(tgt >> 2);
        end
        default: ;
      endcase
      if (dst != 0) begin r[dst] = val; lastRet[dst] = t; end
      expPc[expN]   = pcB;
      expCyc[expN]  = t;
      expCTag[expN] = cTag;
      expPTag[expN] = (kind == 5) ? "R5" : (kind == 0) ? "R9" : "R2";
      if (taken && nextIdx == pcIdx) loops++;
      prevRet = t; prevTaken = taken; pcIdx = nextIdx;
      expN++;
    end
  endtask

  task automatic runProgram(string name);
    int cyc, rc, sc;
    runIss();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) dmem[i] = dmemInit[i];
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: state held by reset
    check32("R1", {name, " reset retireValid"}, 32'(retireValid), 32'd0);
    check32("R1", {name, " reset dmemWrEn"}, 32'(dmemWrEn), 32'd0);
    check32("R1", {name, " reset imemAddr"}, imemAddr, 32'd0);
    rst = 1'b0;
    cyc = 0; rc = 0; sc = 0;
    while (rc < expN && cyc < expCyc[expN-1] + 40) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (dmemWrEn) begin
        if (sc < expNs) begin
          check32("R4", {name, " store address"}, dmemAddr, expSa[sc]);
          check32(expSTag[sc], {name, " store data"}, dmemWrData, expSd[sc]);
        end else begin
          check32("R7", {name, " unexpected store"}, dmemAddr, 32'hFFFF_FFFF);
        end
        sc++;
      end
      if (retireValid) begin
        if (rc < expN) begin
          check32(expPTag[rc], {name, " retire pc"}, retirePc, expPc[rc]);
          check32(expCTag[rc], {name, " retire cycle"}, 32'(cyc), 32'(expCyc[rc]));
        end
        rc++;
      end
    end
    check32("R2", {name, " retire count"}, 32'(rc), 32'(expN));
    check32("R7", {name, " store count"}, 32'(sc), 32'(expNs));
  endtask

  task automatic loadDirected();
    for (int i = 0; i < 64; i++) begin
      imem[i] = '0;
      dmemInit[i] = 32'(i) * 32'h0101_0101 + 32'h10;
    end
    imem[0]  = encI(6'h23, 0, 1, 16'd4);        // lw r1
    imem[1]  = encI(6'h23, 0, 2, 16'd8);        // lw r2
    imem[2]  = encR(6'h20, 3, 1, 2);            // R6 distance one
    imem[3]  = encR(6'h22, 4, 3, 1);            // R3 sub, dependent
    imem[4]  = encI(6'h2B, 0, 4, 16'd16);       // sw r4
    imem[5]  = encR(6'h20, 0, 1, 2);            // R8 write to r0
    imem[6]  = encI(6'h2B, 0, 0, 16'd20);       // R8 store r0
    imem[7]  = 32'hFC00_0000;                   // R9 unknown word
    imem[8]  = encI(6'h04, 1, 1, 16'd1);        // R5 taken
    imem[9]  = encI(6'h2B, 0, 1, 16'd24);       // R7 must be flushed
    imem[10] = encI(6'h04, 1, 2, 16'd1);        // R5 not taken
    imem[11] = encR(6'h20, 5, 1, 1);
    imem[12] = encR(6'h22, 6, 2, 1) | 32'h0000_0040; // R9 nonzero shamt
    imem[13] = '0;
    imem[14] = encI(6'h2B, 0, 5, 16'd28);       // distance three, no stall
    imem[15] = encI(6'h2B, 0, 6, 16'hFFFC);     // negative offset, r6 untouched
    imem[16] = encI(6'h04, 0, 0, 16'hFFFF);     // self loop
  endtask

  task automatic loadRandom();
    for (int i = 0; i < 64; i++) begin
      imem[i] = '0;
      dmemInit[i] = $urandom;
    end
    for (int i = 0; i < PLEN - 1; i++) begin
      int sel, ra, rb, rc2, maxOff, off;
      logic [15:0] imm;
      sel = int'($urandom % 100);
      ra = int'($urandom % 8); rb = int'($urandom % 8); rc2 = int'($urandom % 8);
      imm = ($urandom % 4 == 0) ? 16'hFFFC : 16'(($urandom % 64) * 4);
      if (sel < 25)       imem[i] = encR(6'h20, rc2, ra, rb);
      else if (sel < 45)  imem[i] = encR(6'h22, rc2, ra, rb);
      else if (sel < 65)  imem[i] = encI(6'h23, ra, rb, imm);
      else if (sel < 80)  imem[i] = encI(6'h2B, ra, rb, imm);
      else if (sel < 92) begin
        maxOff = (PLEN - 2) - i;
        if (maxOff > 3) maxOff = 3;
        off = int'($urandom % (maxOff + 1));
        imem[i] = encI(6'h04, ra, rb, 16'(off));
      end else imem[i] = 32'hFC00_0000 | 32'($urandom % 1024);
    end
    imem[PLEN-1] = encI(6'h04, 0, 0, 16'hFFFF);
  endtask

  initial begin
    void'($urandom(32'h0005_EED1));
    loadDirected();
    runProgram("directed");
    for (int p = 0; p < 6; p++) begin
      loadRandom();
      runProgram("random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule